// File: doc/BRIEF.md
# Overcurrent alert-trip-recovery channel

This block is one discharge-overcurrent protection channel. Every clock cycle it takes a sample and compares the measured quantity against a programmable limit. The elaboration parameter `VARIANT` selects what is measured:

- **Voltage variant:** an unsigned sense-resistor differential in millivolts.
- **Current variant:** a signed current, where negative values mean discharge.

When the limit is first crossed, the channel raises an alert. If the crossing lasts without a break for a programmable number of timebase ticks, the alert turns into a latched fault. Entering the fault emits a one-cycle trip pulse. It can also ask for the discharge FET to be switched off, if autonomous FET control is enabled at that moment.

A latched fault is held until a charging current above a recovery threshold has lasted for a programmed number of consecutive ticks. Every timer in the block advances only on the timebase tick, so one design serves both a millisecond-scale timebase and a one-second timebase. Dropping the channel enable clears every output and timer.

Top module: `ocd_channel`

## Requirements
- R1: In the voltage variant, the limit in mV is 4 + 2 × min(thr_code, 98). The channel is abnormal only when `sense` is strictly greater than that limit.
- R2: In the current variant, the channel is abnormal when the signed `cur` is less than or equal to −thr_code.
- R3: `alert` goes high in the cycle after the first abnormal sample, and `alert` and `status` are never high together.
- R4: From the alert state, the fault is entered on the tick that completes a continuous abnormal run. That run is 2 + dly_code ticks in the voltage variant and dly_code ticks in the current variant, counted from the first tick after the alert rose. In the current variant, dly_code = 0 sets `status` in the cycle after the first abnormal sample, without any alert.
- R5: A normal sample before the delay expires clears `alert` in the next cycle and restarts the persistence count from zero.
- R6: On entering the fault, `status` sets, `alert` clears and `trip` is high for exactly one cycle.
- R7: `fet_off` sets together with `status` only if `afet_en` is high in the trip cycle, and it clears when `status` clears.
- R8: While `status` is high, it clears after rec_time consecutive ticks (at least one) with `cur` > `rec_thr`. A cycle with `cur` ≤ `rec_thr` restarts that count.
- R9: While `en` is low, `alert`, `status`, `trip` and `fet_off` are low from the next cycle on, and both timers restart.
- R10: The persistence and recovery counts advance only in cycles where `tick` is high.
- R11: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel enable |
| sense | input | SENSE_W | Sensed differential in mV (voltage variant) |
| thr_code | input | THR_W | Threshold code (mV step code or current magnitude) |
| dly_code | input | DLY_W | Trip delay code in ticks |
| afet_en | input | 1 | Autonomous FET control enable |
| cur | input | CUR_W | Signed current, negative means discharge |
| rec_thr | input | CUR_W | Signed recovery current threshold |
| rec_time | input | RT_W | Recovery time in ticks |
| tick | input | 1 | Timebase tick strobe |
| alert | output | 1 | Abnormal condition seen, fault not yet latched |
| status | output | 1 | Latched fault |
| fet_off | output | 1 | Discharge FET off request |
| trip | output | 1 | One-cycle pulse on fault entry |

## Verification
The bench drives both comparators exactly at their limits (equal to the threshold, and one LSB beyond it) and includes a code above the clamp. A design with an off-by-one or inclusive comparison would therefore alert one step early. It interleaves non-tick cycles into the delay windows and inserts a one-sample return to normal and a one-cycle current dip during recovery. A design that counted clocks instead of ticks, or that kept a stale count, would trip or release early. It also covers the zero-delay shortcut of the current variant, a trip with autonomous FET control off, and an enable drop in both the alert and the fault state. A design that leaked an alert, kept the FET request, or ignored the enable would then show the wrong outputs.

// File: rtl/ocd_pkg.sv
package ocd_pkg;

    localparam int unsigned LIM_W        = 16;
    localparam int unsigned THR_CODE_MAX = 98;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALERT = 2'd1,
        ST_FAULT = 2'd2
    } ocd_state_e;

    typedef enum logic {
        VAR_VOLT = 1'b0,
        VAR_CURR = 1'b1
    } ocd_variant_e;

    typedef struct packed {
        logic alert;
        logic status;
        logic fet_off;
        logic trip;
    } ocd_out_t;

    // Millivolt limit from a step code, clamped to the top step
    function automatic logic [LIM_W-1:0] volt_thr_mv(input logic [LIM_W-1:0] code);
        logic [LIM_W-1:0] c;
        c = (code > LIM_W'(THR_CODE_MAX)) ? LIM_W'(THR_CODE_MAX) : code;
        return LIM_W'(4) + (c << 1);
    endfunction

    // Number of abnormal ticks needed before the fault latches
    function automatic logic [LIM_W-1:0] persist_limit(input ocd_variant_e v,
                                                       input logic [LIM_W-1:0] code);
        return (v == VAR_VOLT) ? code + LIM_W'(2) : code;
    endfunction

    // Recovery tick count, never below one
    function automatic logic [LIM_W-1:0] rec_limit(input logic [LIM_W-1:0] code);
        return (code == '0) ? LIM_W'(1) : code;
    endfunction

endpackage

// File: rtl/ocd_detect.sv
module ocd_detect
    import ocd_pkg::*;
#(
    parameter ocd_variant_e VARIANT = VAR_VOLT,
    parameter int unsigned  SENSE_W = 8,
    parameter int unsigned  THR_W   = 8,
    parameter int unsigned  CUR_W   = 16
) (
    input  logic                    en,
    input  logic [SENSE_W-1:0]      sense,
    input  logic signed [CUR_W-1:0] cur,
    input  logic [THR_W-1:0]        thr_code,
    output logic                    abn
);

    localparam int unsigned XW = CUR_W + 1;

    logic [LIM_W-1:0]    thr_mv;
    logic                v_abn;
    logic signed [XW-1:0] cur_x;
    logic signed [XW-1:0] neg_thr;
    logic                c_abn;

    // Voltage comparator: strictly above the stepped limit
    assign thr_mv = volt_thr_mv(LIM_W'(thr_code));
    assign v_abn  = LIM_W'(sense) > thr_mv;

    // Current comparator: at or below the negated magnitude
    assign cur_x   = {cur[CUR_W-1], cur};
    assign neg_thr = -$signed({{(XW-THR_W){1'b0}}, thr_code});
    assign c_abn   = cur_x <= neg_thr;

    always_comb begin
        abn = en && ((VARIANT == VAR_CURR) ? c_abn : v_abn);
    end

endmodule

// File: rtl/ocd_tick_timer.sv
module ocd_tick_timer
    import ocd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [LIM_W-1:0] limit,
    output logic             done
);

    logic [LIM_W-1:0] cnt;
    logic [LIM_W-1:0] cnt_nxt;

    assign cnt_nxt = cnt + LIM_W'(1);
    assign done    = run && tick && (cnt_nxt >= limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick && !done) begin
            cnt <= cnt_nxt;
        end
    end

endmodule

// File: rtl/ocd_ctrl.sv
module ocd_ctrl
    import ocd_pkg::*;
#(
    parameter ocd_variant_e VARIANT = VAR_VOLT
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       abn,
    input  logic       dly_zero,
    input  logic       afet_en,
    input  logic       pers_done,
    input  logic       rec_done,
    output ocd_state_e state,
    output ocd_out_t   outs
);

    ocd_state_e nxt;
    logic       fire;

    always_comb begin
        nxt  = state;
        fire = 1'b0;
        case (state)
            ST_IDLE: begin
                if (abn) begin
                    if (VARIANT == VAR_CURR && dly_zero) begin
                        nxt  = ST_FAULT;
                        fire = 1'b1;
                    end else begin
                        nxt = ST_ALERT;
                    end
                end
            end
            ST_ALERT: begin
                if (!abn) begin
                    nxt = ST_IDLE;
                end else if (pers_done) begin
                    nxt  = ST_FAULT;
                    fire = 1'b1;
                end
            end
            ST_FAULT: begin
                if (rec_done) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
        if (!en) begin
            nxt  = ST_IDLE;
            fire = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            outs  <= '0;
        end else begin
            state        <= nxt;
            outs.alert   <= (nxt == ST_ALERT);
            outs.status  <= (nxt == ST_FAULT);
            outs.trip    <= fire;
            outs.fet_off <= fire ? afet_en : ((nxt == ST_FAULT) && outs.fet_off);
        end
    end

endmodule

// File: rtl/ocd_channel.sv
module ocd_channel
    import ocd_pkg::*;
#(
    parameter ocd_variant_e VARIANT = VAR_VOLT,
    parameter int unsigned  SENSE_W = 8,
    parameter int unsigned  THR_W   = 8,
    parameter int unsigned  DLY_W   = 8,
    parameter int unsigned  CUR_W   = 16,
    parameter int unsigned  RT_W    = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic [SENSE_W-1:0]      sense,
    input  logic [THR_W-1:0]        thr_code,
    input  logic [DLY_W-1:0]        dly_code,
    input  logic                    afet_en,
    input  logic signed [CUR_W-1:0] cur,
    input  logic signed [CUR_W-1:0] rec_thr,
    input  logic [RT_W-1:0]         rec_time,
    input  logic                    tick,
    output logic                    alert,
    output logic                    status,
    output logic                    fet_off,
    output logic                    trip
);

    logic             abn;
    logic             dly_zero;
    logic             rec_cond;
    logic             pers_run;
    logic             rec_run;
    logic             pers_done;
    logic             rec_done;
    logic [LIM_W-1:0] pers_lim;
    logic [LIM_W-1:0] rec_lim;
    ocd_state_e       state;
    ocd_out_t         outs;

    ocd_detect #(
        .VARIANT (VARIANT),
        .SENSE_W (SENSE_W),
        .THR_W   (THR_W),
        .CUR_W   (CUR_W)
    ) u_detect (
        .en       (en),
        .sense    (sense),
        .cur      (cur),
        .thr_code (thr_code),
        .abn      (abn)
    );

    assign dly_zero = (dly_code == '0);
    assign rec_cond = cur > rec_thr;
    assign pers_lim = persist_limit(VARIANT, LIM_W'(dly_code));
    assign rec_lim  = rec_limit(LIM_W'(rec_time));
    assign pers_run = en && (state == ST_ALERT) && abn;
    assign rec_run  = en && (state == ST_FAULT) && rec_cond;

    ocd_tick_timer u_persist (
        .clk   (clk),
        .rst   (rst),
        .run   (pers_run),
        .tick  (tick),
        .limit (pers_lim),
        .done  (pers_done)
    );

    ocd_tick_timer u_recover (
        .clk   (clk),
        .rst   (rst),
        .run   (rec_run),
        .tick  (tick),
        .limit (rec_lim),
        .done  (rec_done)
    );

    ocd_ctrl #(
        .VARIANT (VARIANT)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .abn       (abn),
        .dly_zero  (dly_zero),
        .afet_en   (afet_en),
        .pers_done (pers_done),
        .rec_done  (rec_done),
        .state     (state),
        .outs      (outs)
    );

    assign alert   = outs.alert;
    assign status  = outs.status;
    assign fet_off = outs.fet_off;
    assign trip    = outs.trip;

endmodule

// File: rtl/ocd_channel_chk.sv
module ocd_channel_chk #(
    parameter int unsigned CUR_W = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    en,
    input logic                    tick,
    input logic signed [CUR_W-1:0] cur,
    input logic signed [CUR_W-1:0] rec_thr,
    input logic                    alert,
    input logic                    status,
    input logic                    fet_off,
    input logic                    trip
);

    // R3
    excl_alert_status_chk: assert property (@(posedge clk) disable iff (rst)
        !(alert && status));

    // R6
    trip_edge_chk: assert property (@(posedge clk) disable iff (rst)
        trip |-> (status && !$past(status)));

    // R6
    status_rise_trip_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status) |-> trip);

    // R7
    fet_needs_status_chk: assert property (@(posedge clk) disable iff (rst)
        fet_off |-> status);

    // R9
    disable_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!alert && !status && !trip && !fet_off));

    // R8
    release_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(status) |-> $past(rst || !en || (tick && (cur > rec_thr))));

    // R10
    trip_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (trip && $past(alert)) |-> $past(tick));

endmodule

bind ocd_channel ocd_channel_chk #(.CUR_W(CUR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .tick    (tick),
    .cur     (cur),
    .rec_thr (rec_thr),
    .alert   (alert),
    .status  (status),
    .fet_off (fet_off),
    .trip    (trip)
);

// File: tb/ocd_channel_tb_top.sv
`timescale 1ns/1ps
module ocd_channel_tb_top;
    import ocd_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst = 1'b1;
    logic               en = 1'b1;
    logic               afet = 1'b1;
    logic               tick = 1'b0;
    logic signed [15:0] rec_thr = 16'sd0;
    logic [7:0]         rec_time = 8'd2;

    logic [7:0]         v_sense = 8'd0;
    logic [7:0]         v_thr = 8'd10;
    logic [7:0]         v_dly = 8'd1;
    logic signed [15:0] v_cur = 16'sd0;
    logic               v_alert, v_status, v_fet, v_trip;

    logic [7:0]         c_sense = 8'd0;
    logic [7:0]         c_thr = 8'd50;
    logic [7:0]         c_dly = 8'd0;
    logic signed [15:0] c_cur = 16'sd0;
    logic               c_alert, c_status, c_fet, c_trip;

    int checks = 0;
    int errors = 0;

    ocd_channel #(.VARIANT(VAR_VOLT)) dut_i (
        .clk(clk), .rst(rst), .en(en), .sense(v_sense), .thr_code(v_thr),
        .dly_code(v_dly), .afet_en(afet), .cur(v_cur), .rec_thr(rec_thr),
        .rec_time(rec_time), .tick(tick), .alert(v_alert), .status(v_status),
        .fet_off(v_fet), .trip(v_trip)
    );

    ocd_channel #(.VARIANT(VAR_CURR)) dut_c (
        .clk(clk), .rst(rst), .en(en), .sense(c_sense), .thr_code(c_thr),
        .dly_code(c_dly), .afet_en(afet), .cur(c_cur), .rec_thr(rec_thr),
        .rec_time(rec_time), .tick(tick), .alert(c_alert), .status(c_status),
        .fet_off(c_fet), .trip(c_trip)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic tstep();
        tick = 1'b1;
        step();
        tick = 1'b0;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        check("R11", "v alert", v_alert, 0);
        check("R11", "v status", v_status, 0);
        check("R11", "v fet_off", v_fet, 0);
        check("R11", "c status", c_status, 0);
        check("R11", "c trip", c_trip, 0);
    endtask

    task automatic t_volt_thresh();
        v_thr = 8'd10;              // limit 24 mV
        v_sense = 8'd24; step();
        check("R1", "equal limit no alert", v_alert, 0);
        v_sense = 8'd25; step();
        check("R1", "above limit alert", v_alert, 1);
        v_sense = 8'd24; step();
        check("R5", "normal clears alert", v_alert, 0);
        v_thr = 8'd120;             // clamps to 200 mV
        v_sense = 8'd200; step();
        check("R1", "clamped equal no alert", v_alert, 0);
        v_sense = 8'd201; step();
        check("R1", "clamped above alert", v_alert, 1);
        v_sense = 8'd0; v_thr = 8'd10; step();
    endtask

    task automatic t_volt_trip();
        v_dly = 8'd1; afet = 1'b1;  // 3 ticks
        v_sense = 8'd30; step();
        check("R3", "alert after first sample", v_alert, 1);
        repeat (5) step();
        check("R10", "no tick no trip", v_status, 0);
        tstep();
        tstep();
        check("R4", "still alert after 2 ticks", v_alert, 1);
        check("R4", "no fault after 2 ticks", v_status, 0);
        tstep();
        check("R4", "fault after 3 ticks", v_status, 1);
        check("R6", "alert cleared at fault", v_alert, 0);
        check("R6", "trip pulse", v_trip, 1);
        check("R7", "fet_off with afet", v_fet, 1);
        v_sense = 8'd0; step();
        check("R6", "trip one cycle", v_trip, 0);
        check("R6", "status held", v_status, 1);
        v_cur = 16'sd0;
        tstep(); tstep(); tstep();
        check("R8", "no recovery at threshold", v_status, 1);
        v_cur = 16'sd5; tstep();
        v_cur = 16'sd0; step();
        v_cur = 16'sd5; tstep();
        check("R8", "dip restarts recovery", v_status, 1);
        tstep();
        check("R8", "recovered", v_status, 0);
        check("R7", "fet_off clears", v_fet, 0);
        v_cur = 16'sd0;
    endtask

    task automatic t_persist_reset();
        v_dly = 8'd0;               // 2 ticks
        v_sense = 8'd30; step();
        tstep();
        v_sense = 8'd0; step();
        check("R5", "alert cleared on normal", v_alert, 0);
        v_sense = 8'd30; step();
        tstep();
        check("R5", "count restarted", v_status, 0);
        tstep();
        check("R5", "fault after fresh count", v_status, 1);
        v_sense = 8'd0; v_cur = 16'sd5; rec_time = 8'd0;
        tstep();
        check("R8", "rec_time zero acts as one", v_status, 0);
        rec_time = 8'd2; v_cur = 16'sd0;
    endtask

    task automatic t_afet_off();
        afet = 1'b0; v_dly = 8'd0;
        v_sense = 8'd30; step();
        tstep(); tstep();
        check("R7", "status without afet", v_status, 1);
        check("R7", "no fet_off without afet", v_fet, 0);
        v_sense = 8'd0; v_cur = 16'sd5;
        tstep(); tstep();
        check("R8", "recovered", v_status, 0);
        v_cur = 16'sd0; afet = 1'b1;
    endtask

    task automatic t_current();
        c_thr = 8'd50; c_dly = 8'd0;
        c_cur = -16'sd49; step();
        check("R2", "above neg thr normal", c_alert | c_status, 0);
        c_cur = -16'sd50; step();
        check("R4", "zero delay direct fault", c_status, 1);
        check("R4", "zero delay no alert", c_alert, 0);
        check("R2", "trip at equal thr", c_trip, 1);
        c_cur = 16'sd5; tstep(); tstep();
        check("R8", "current recovered", c_status, 0);
        c_dly = 8'd2;
        c_cur = -16'sd80; step();
        check("R2", "alert on discharge", c_alert, 1);
        tstep();
        check("R4", "not yet after 1 tick", c_status, 0);
        tstep();
        check("R4", "fault after 2 ticks", c_status, 1);
        c_cur = 16'sd5; tstep(); tstep();
        check("R8", "current recovered again", c_status, 0);
        c_cur = 16'sd0;
    endtask

    task automatic t_enable();
        v_dly = 8'd0;
        v_sense = 8'd30; step();
        check("R9", "alert before disable", v_alert, 1);
        en = 1'b0; step();
        check("R9", "alert off when disabled", v_alert, 0);
        tstep(); tstep(); tstep();
        check("R9", "no fault when disabled", v_status, 0);
        check("R9", "no trip when disabled", v_trip, 0);
        en = 1'b1; step();
        check("R9", "alert back", v_alert, 1);
        tstep();
        check("R9", "timer restarted", v_status, 0);
        tstep();
        check("R9", "fault after re-enable", v_status, 1);
        en = 1'b0; step();
        check("R9", "status cleared by disable", v_status, 0);
        check("R9", "fet_off cleared by disable", v_fet, 0);
        en = 1'b1; v_sense = 8'd0; step();
    endtask

    initial begin
        t_reset();
        t_volt_thresh();
        t_volt_trip();
        t_persist_reset();
        t_afet_off();
        t_current();
        t_enable();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule